// File: doc/BRIEF.md
# Three-Channel Compare-Match Timer

This block holds three independent 16-bit up-counters that software programs over a simple synchronous register bus. Each channel has its own counting clock. The clock is the system clock divided by 1, 4, 16 or 64, or edges of one shared external input. One register shared by all channels starts and stops them. When a channel's counter equals its compare register on a counting tick, the channel sets a sticky event flag. It can also restart its count from zero, and it applies a programmed action to its two output pins.

The usual use is a periodic tick. Software sets a divider and a compare value, selects "restart on compare", enables the interrupt and sets the channel's run bit. The interrupt output then stays high once per period until software clears the flag. Each register is eight bits wide except the counter and the compare value, which are sixteen. Reads are combinational from the address. Writes take effect at the clock edge where `bus_wr` is high.

Top module: `tmr_unit`

## Requirements
- R1: After synchronous reset every register reads 0, and `irq`, `pin_a` and `pin_b` are all 0.
- R2: The run register is at address 0x280, and bit i of it runs channel i. While a channel's bit is 0 its counter holds its value.
- R3: Channel 0, 1 and 2 registers start at 0x300, 0x380 and 0x000. Within a block the offsets are: +0 control, +1 mode, +2 pin control, +4 interrupt enable, +5 status, +6 counter, +8 compare. Unused offsets read 0.
- R4: Control bits [2:0] pick the counting clock. Codes 0 to 3 give one tick every 1, 4, 16 or 64 clock cycles. Code 4 counts external input edges. Codes 5 to 7 never tick. The divider starts from zero each time the run bit goes from 0 to 1.
- R5: With code 4, control bits [4:3] pick the external edge: 0 rising, 1 falling, 2 both, 3 rising.
- R6: Control bits [7:5] pick the clear source. With value 1, a tick taken while the counter equals the compare value loads 0, so the period is compare+1 ticks. With any other value the counter keeps counting and wraps from 0xFFFF to 0.
- R7: The counter advances only while mode bits [3:0] are 0. Mode bits [7:4] have no effect.
- R8: Status bit 0 sets on every compare-match tick. Writing status with bit 0 at 0 clears the flag, and writing 1 leaves it as it was. A match in the same cycle as a clear leaves the flag set.
- R9: `irq[i]` is high exactly while channel i's status bit 0 and its enable bit 0 are both 1.
- R10: The pin control high nibble drives `pin_a` and the low nibble drives `pin_b`. Writing the register sets the pin to 0 for codes 1-3 and to 1 for codes 5-7; any other code leaves the pin unchanged. On a match, codes 1/5 clear the pin, 2/6 set it and 3/7 toggle it. Codes 0, 4 and 8-15 do nothing.
- R11: A counter write in a cycle wins over counting and clearing. The counter takes the written value, and that cycle produces no match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 10 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| ext_in | input | 1 | External count input, edge detected |
| irq | output | 3 | Per-channel level interrupt |
| pin_a | output | 3 | Per-channel compare output A |
| pin_b | output | 3 | Per-channel compare output B |

## Verification
One channel runs a periodic restart with divide-by-1. That separates a period of compare+1 ticks from compare ticks, and shows the toggle and set pin actions landing on the same cycle as the flag. A second channel runs free at divide-by-4, 16 and 64, with stops and restarts, so a divider that does not restart on the run edge or a wrong divide ratio shows up in the counter value. The third channel counts external edges under each edge code and under the no-count codes, which tells rising, falling and both-edge counting apart. Counter writes near the wrap point, halting mode values, clear codes other than 1, and status writes of 0 and of 1 cover the priority and sticky-flag corners.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int NUM_CH  = 3;
    localparam int CNT_W   = 16;
    localparam int ADDR_W  = 10;
    localparam int DATA_W  = 16;
    localparam int REG_W   = 8;
    localparam int PDIV_W  = 6;
    localparam int OFS_W   = 4;

    localparam logic [ADDR_W-1:0] START_ADDR = 10'h280;

    typedef enum logic [OFS_W-1:0] {
        OFS_CTRL  = 4'd0,
        OFS_MODE  = 4'd1,
        OFS_PINS  = 4'd2,
        OFS_IEN   = 4'd4,
        OFS_STAT  = 4'd5,
        OFS_COUNT = 4'd6,
        OFS_CMP   = 4'd8
    } reg_ofs_e;

    typedef struct packed {
        logic [2:0] clr_src;
        logic [1:0] edge_sel;
        logic [2:0] clk_sel;
    } ctrl_t;

    localparam logic [2:0] CLR_ON_CMP = 3'd1;
    localparam logic [2:0] CLK_EXT    = 3'd4;
    localparam logic [1:0] EDGE_FALL  = 2'd1;
    localparam logic [1:0] EDGE_BOTH  = 2'd2;

    function automatic logic [ADDR_W-1:0] chan_base(input int idx);
        case (idx)
            0:       return 10'h300;
            1:       return 10'h380;
            default: return 10'h000;
        endcase
    endfunction

    function automatic logic [PDIV_W-1:0] div_last(input logic [2:0] sel);
        case (sel)
            3'd0:    return 6'd0;
            3'd1:    return 6'd3;
            3'd2:    return 6'd15;
            default: return 6'd63;
        endcase
    endfunction

    function automatic logic pin_init(input logic [3:0] code, input logic cur);
        if (code[3]) return cur;
        case (code[2:0])
            3'd1, 3'd2, 3'd3: return 1'b0;
            3'd5, 3'd6, 3'd7: return 1'b1;
            default:          return cur;
        endcase
    endfunction

    function automatic logic pin_on_match(input logic [3:0] code, input logic cur);
        if (code[3]) return cur;
        case (code[1:0])
            2'd1:    return 1'b0;
            2'd2:    return 1'b1;
            2'd3:    return ~cur;
            default: return cur;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [2:0] clk_sel,
    input  logic [1:0] edge_sel,
    input  logic       ext_rise,
    input  logic       ext_fall,
    output logic       tick
);

    logic [PDIV_W-1:0] pcnt;
    logic              int_mode;
    logic              int_tick;
    logic              edge_hit;

    always_comb begin
        int_mode = (clk_sel < CLK_EXT);
        int_tick = run && int_mode && (pcnt == div_last(clk_sel));
        case (edge_sel)
            EDGE_FALL: edge_hit = ext_fall;
            EDGE_BOTH: edge_hit = ext_rise | ext_fall;
            default:   edge_hit = ext_rise;
        endcase
        tick = int_tick || (run && (clk_sel == CLK_EXT) && edge_hit);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pcnt <= '0;
        end else if (int_mode) begin
            pcnt <= int_tick ? '0 : pcnt + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              ext_rise,
    input  logic              ext_fall,
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              pin_a,
    output logic              pin_b,
    output logic [CNT_W-1:0]  cnt,
    output logic              flag,
    output logic              match,
    output logic              cnt_wr,
    output logic              clr_on_cmp
);

    localparam int PAD_W = DATA_W - REG_W;

    ctrl_t             ctrl_r;
    logic [REG_W-1:0]  mode_r;
    logic [REG_W-1:0]  pins_r;
    logic [REG_W-1:0]  ien_r;
    logic [CNT_W-1:0]  cmp_r;
    logic              tick;
    logic              count_en;
    logic              stat_wr;
    logic              pins_wr;

    tmr_prescaler u_presc (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .clk_sel  (ctrl_r.clk_sel),
        .edge_sel (ctrl_r.edge_sel),
        .ext_rise (ext_rise),
        .ext_fall (ext_fall),
        .tick     (tick)
    );

    always_comb begin
        cnt_wr     = wr_en && (ofs == OFS_COUNT);
        stat_wr    = wr_en && (ofs == OFS_STAT);
        pins_wr    = wr_en && (ofs == OFS_PINS);
        count_en   = tick && (mode_r[3:0] == 4'd0);
        match      = count_en && !cnt_wr && (cnt == cmp_r);
        clr_on_cmp = (ctrl_r.clr_src == CLR_ON_CMP);
        irq        = flag && ien_r[0];
    end

    always_comb begin
        case (ofs)
            OFS_CTRL:  rdata = {{PAD_W{1'b0}}, ctrl_r};
            OFS_MODE:  rdata = {{PAD_W{1'b0}}, mode_r};
            OFS_PINS:  rdata = {{PAD_W{1'b0}}, pins_r};
            OFS_IEN:   rdata = {{PAD_W{1'b0}}, ien_r};
            OFS_STAT:  rdata = {{(DATA_W-1){1'b0}}, flag};
            OFS_COUNT: rdata = cnt;
            OFS_CMP:   rdata = cmp_r;
            default:   rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_r <= '0;
            mode_r <= '0;
            pins_r <= '0;
            ien_r  <= '0;
            cmp_r  <= '0;
        end else if (wr_en) begin
            case (ofs)
                OFS_CTRL: ctrl_r <= ctrl_t'(wdata[REG_W-1:0]);
                OFS_MODE: mode_r <= wdata[REG_W-1:0];
                OFS_PINS: pins_r <= wdata[REG_W-1:0];
                OFS_IEN:  ien_r  <= wdata[REG_W-1:0];
                OFS_CMP:  cmp_r  <= wdata[CNT_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt_wr) begin
            cnt <= wdata[CNT_W-1:0];
        end else if (count_en) begin
            cnt <= (match && clr_on_cmp) ? '0 : cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (match) begin
            flag <= 1'b1;
        end else if (stat_wr) begin
            flag <= flag & wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_a <= 1'b0;
            pin_b <= 1'b0;
        end else if (pins_wr) begin
            pin_a <= pin_init(wdata[7:4], pin_a);
            pin_b <= pin_init(wdata[3:0], pin_b);
        end else if (match) begin
            pin_a <= pin_on_match(pins_r[7:4], pin_a);
            pin_b <= pin_on_match(pins_r[3:0], pin_b);
        end
    end

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ext_in,
    output logic [NUM_CH-1:0] irq,
    output logic [NUM_CH-1:0] pin_a,
    output logic [NUM_CH-1:0] pin_b
);

    logic [NUM_CH-1:0]             run_vec;
    logic                          ext_prev;
    logic                          ext_rise;
    logic                          ext_fall;
    logic                          start_hit;
    logic [NUM_CH-1:0]             ch_hit;
    logic [NUM_CH-1:0][DATA_W-1:0] ch_rdata;
    logic [NUM_CH-1:0][CNT_W-1:0]  cnt_vec;
    logic [NUM_CH-1:0]             flag_vec;
    logic [NUM_CH-1:0]             match_vec;
    logic [NUM_CH-1:0]             cnt_wr_vec;
    logic [NUM_CH-1:0]             clr_a_vec;

    always_comb begin
        start_hit = (bus_addr == START_ADDR);
        ext_rise  = ext_in && !ext_prev;
        ext_fall  = !ext_in && ext_prev;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_vec  <= '0;
            ext_prev <= 1'b0;
        end else begin
            ext_prev <= ext_in;
            if (bus_wr && start_hit) begin
                run_vec <= bus_wdata[NUM_CH-1:0];
            end
        end
    end

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            localparam logic [ADDR_W-1:0] BASE = chan_base(g);

            assign ch_hit[g] = (bus_addr[ADDR_W-1:OFS_W] == BASE[ADDR_W-1:OFS_W]);

            tmr_channel u_ch (
                .clk        (clk),
                .rst        (rst),
                .run        (run_vec[g]),
                .ext_rise   (ext_rise),
                .ext_fall   (ext_fall),
                .wr_en      (bus_wr && ch_hit[g]),
                .ofs        (bus_addr[OFS_W-1:0]),
                .wdata      (bus_wdata),
                .rdata      (ch_rdata[g]),
                .irq        (irq[g]),
                .pin_a      (pin_a[g]),
                .pin_b      (pin_b[g]),
                .cnt        (cnt_vec[g]),
                .flag       (flag_vec[g]),
                .match      (match_vec[g]),
                .cnt_wr     (cnt_wr_vec[g]),
                .clr_on_cmp (clr_a_vec[g])
            );
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        if (start_hit) begin
            bus_rdata = {{(DATA_W-NUM_CH){1'b0}}, run_vec};
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_hit[i]) begin
                bus_rdata = ch_rdata[i];
            end
        end
    end

endmodule

// File: rtl/tmr_unit_checker.sv
module tmr_unit_checker
    import tmr_pkg::*;
(
    input logic                          clk,
    input logic                          rst,
    input logic                          bus_wr,
    input logic [DATA_W-1:0]             bus_wdata,
    input logic [NUM_CH-1:0]             irq,
    input logic [NUM_CH-1:0]             pin_a,
    input logic [NUM_CH-1:0]             pin_b,
    input logic [NUM_CH-1:0]             run_vec,
    input logic [NUM_CH-1:0][CNT_W-1:0]  cnt_vec,
    input logic [NUM_CH-1:0]             flag_vec,
    input logic [NUM_CH-1:0]             match_vec,
    input logic [NUM_CH-1:0]             cnt_wr_vec,
    input logic [NUM_CH-1:0]             clr_a_vec
);

    assert_reset_outputs_R1: assert property (@(posedge clk)
        rst |=> (irq == '0 && pin_a == '0 && pin_b == '0));

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
            assert_stopped_holds_R2: assert property (@(posedge clk) disable iff (rst)
                (!run_vec[g] && !cnt_wr_vec[g]) |=> $stable(cnt_vec[g]));

            assert_clear_on_match_R6: assert property (@(posedge clk) disable iff (rst)
                (match_vec[g] && clr_a_vec[g]) |=> (cnt_vec[g] == '0));

            assert_flag_on_match_R8: assert property (@(posedge clk) disable iff (rst)
                match_vec[g] |=> flag_vec[g]);

            assert_irq_drop_by_write_R9: assert property (@(posedge clk) disable iff (rst)
                $fell(irq[g]) |-> $past(bus_wr));

            assert_write_wins_R11: assert property (@(posedge clk) disable iff (rst)
                cnt_wr_vec[g] |=> (cnt_vec[g] == $past(bus_wdata)));
        end
    endgenerate

endmodule

bind tmr_unit tmr_unit_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .irq        (irq),
    .pin_a      (pin_a),
    .pin_b      (pin_b),
    .run_vec    (run_vec),
    .cnt_vec    (cnt_vec),
    .flag_vec   (flag_vec),
    .match_vec  (match_vec),
    .cnt_wr_vec (cnt_wr_vec),
    .clr_a_vec  (clr_a_vec)
);

// File: tb/tmr_unit_bench.sv
module tmr_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        ext_in = 1'b0;
    logic [2:0]  irq;
    logic [2:0]  pin_a;
    logic [2:0]  pin_b;

    always #4 clk = ~clk;

    tmr_unit u_tmr_unit (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ext_in    (ext_in),
        .irq       (irq),
        .pin_a     (pin_a),
        .pin_b     (pin_b)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    int m_ctrl[3], m_mode[3], m_io[3], m_ien[3], m_cmp[3], m_cnt[3];
    int m_flag[3], m_pa[3], m_pb[3], m_pc[3];
    int m_start, m_prev;

    function automatic int ch_of(int a);
        if ((a >> 4) == 'h30) return 0;
        if ((a >> 4) == 'h38) return 1;
        if ((a >> 4) == 'h00) return 2;
        return -1;
    endfunction

    function automatic int base_of(int c);
        return (c == 0) ? 'h300 : (c == 1) ? 'h380 : 'h000;
    endfunction

    function automatic int mread(int a);
        int c;
        c = ch_of(a);
        if (c < 0) return (a == 'h280) ? m_start : 0;
        case (a & 15)
            0: return m_ctrl[c];
            1: return m_mode[c];
            2: return m_io[c];
            4: return m_ien[c];
            5: return m_flag[c];
            6: return m_cnt[c];
            8: return m_cmp[c];
            default: return 0;
        endcase
    endfunction

    function automatic int div_n(int s);
        return (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 16 : 64;
    endfunction

    function automatic int lvl_init(int code, int cur);
        if (code >= 1 && code <= 3) return 0;
        if (code >= 5 && code <= 7) return 1;
        return cur;
    endfunction

    function automatic int lvl_match(int code, int cur);
        if (code == 1 || code == 5) return 0;
        if (code == 2 || code == 6) return 1;
        if (code == 3 || code == 7) return 1 - cur;
        return cur;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference, evaluated on the inputs present at each edge
    always @(posedge clk) begin : model
        int rise, fall, run, tick, sel, edg, o, match;
        if (rst) begin
            for (int c = 0; c < 3; c++) begin
                m_ctrl[c] = 0; m_mode[c] = 0; m_io[c] = 0; m_ien[c] = 0;
                m_cmp[c] = 0; m_cnt[c] = 0; m_flag[c] = 0; m_pa[c] = 0;
                m_pb[c] = 0; m_pc[c] = 0;
            end
            m_start = 0;
            m_prev  = 0;
        end else begin
            rise = (ext_in && m_prev == 0) ? 1 : 0;
            fall = (!ext_in && m_prev == 1) ? 1 : 0;
            for (int c = 0; c < 3; c++) begin
                run  = (m_start >> c) & 1;
                sel  = m_ctrl[c] & 7;
                edg  = (m_ctrl[c] >> 3) & 3;
                tick = 0;
                if (run == 0) begin
                    m_pc[c] = 0;
                end else if (sel < 4) begin
                    if (m_pc[c] == div_n(sel) - 1) begin
                        tick = 1;
                        m_pc[c] = 0;
                    end else begin
                        m_pc[c] = (m_pc[c] + 1) % 64;
                    end
                end else if (sel == 4) begin
                    tick = (edg == 1) ? fall : (edg == 2) ? (rise | fall) : rise;
                end
                o = (bus_wr && ch_of(bus_addr) == c) ? (bus_addr & 15) : -1;
                match = 0;
                if (o == 6) begin
                    m_cnt[c] = bus_wdata;
                end else if (tick == 1 && (m_mode[c] & 15) == 0) begin
                    if (m_cnt[c] == m_cmp[c]) match = 1;
                    if (match == 1 && ((m_ctrl[c] >> 5) & 7) == 1) m_cnt[c] = 0;
                    else m_cnt[c] = (m_cnt[c] + 1) & 'hFFFF;
                end
                if (o == 5) m_flag[c] = m_flag[c] & bus_wdata[0];
                if (match == 1) m_flag[c] = 1;
                if (o == 2) begin
                    m_pa[c] = lvl_init((bus_wdata >> 4) & 15, m_pa[c]);
                    m_pb[c] = lvl_init(bus_wdata & 15, m_pb[c]);
                end else if (match == 1) begin
                    m_pa[c] = lvl_match((m_io[c] >> 4) & 15, m_pa[c]);
                    m_pb[c] = lvl_match(m_io[c] & 15, m_pb[c]);
                end
                case (o)
                    0: m_ctrl[c] = bus_wdata & 255;
                    1: m_mode[c] = bus_wdata & 255;
                    2: m_io[c]   = bus_wdata & 255;
                    4: m_ien[c]  = bus_wdata & 255;
                    8: m_cmp[c]  = bus_wdata;
                    default: ;
                endcase
            end
            m_prev = ext_in ? 1 : 0;
            if (bus_wr && bus_addr == 'h280) m_start = bus_wdata & 7;
        end
    end

    // outputs compared on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            for (int c = 0; c < 3; c++) begin
                check(irq[c] == ((m_flag[c] & m_ien[c]) & 1), "R9 irq level", irq[c], (m_flag[c] & m_ien[c]) & 1);
                check(pin_a[c] == m_pa[c][0], "R10 pin_a", pin_a[c], m_pa[c]);
                check(pin_b[c] == m_pb[c][0], "R10 pin_b", pin_b[c], m_pb[c]);
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int a, int d);
        bus_addr  = a[9:0];
        bus_wdata = d[15:0];
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd_chk(int a, string tag);
        int exp;
        bus_addr = a[9:0];
        #1;
        exp = mread(a);
        check(bus_rdata == exp[15:0], tag, bus_rdata, exp);
    endtask

    task automatic sweep(string tag);
        rd_chk('h280, tag);
        for (int c = 0; c < 3; c++) begin
            for (int o = 0; o < 9; o++) begin
                rd_chk(base_of(c) + o, tag);
            end
        end
    endtask

    task automatic toggle(int n);
        repeat (n) begin
            ext_in = ~ext_in;
            idle(3);
        end
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired, run did not finish");
        done = 1;
        summary();
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        check(irq == 0 && pin_a == 0 && pin_b == 0, "R1 outputs after reset", {irq, pin_a, pin_b}, 0);
        sweep("R1 registers after reset");

        // periodic restart on channel 0, divide by 1, compare 5
        wr('h300, 'h20);
        wr('h308, 5);
        wr('h304, 1);
        wr('h302, 'h23);
        wr('h280, 1);
        idle(40);
        rd_chk('h306, "R6 periodic counter");
        rd_chk('h305, "R8 flag set");

        // stop and hold, then flag write semantics
        wr('h280, 0);
        rd_chk('h306, "R2 stopped counter");
        idle(10);
        rd_chk('h306, "R2 counter held");
        wr('h305, 1);
        rd_chk('h305, "R8 write one keeps flag");
        wr('h305, 0);
        rd_chk('h305, "R8 write zero clears flag");

        // channel 1 free running under each internal divider
        wr('h380, 'h01);
        wr('h388, 3);
        wr('h384, 1);
        wr('h280, 2);
        idle(50);
        rd_chk('h386, "R4 divide by 4");
        wr('h280, 0);
        wr('h380, 'h02);
        wr('h386, 0);
        wr('h280, 2);
        idle(100);
        rd_chk('h386, "R4 divide by 16");
        wr('h280, 0);
        wr('h380, 'h03);
        wr('h280, 2);
        idle(300);
        rd_chk('h386, "R4 divide by 64");
        wr('h280, 0);
        wr('h280, 2);
        idle(70);
        rd_chk('h386, "R4 divider restart on run");

        // halting mode values
        wr('h381, 2);
        idle(140);
        rd_chk('h386, "R7 nonzero mode halts");
        wr('h381, 'h10);
        idle(140);
        rd_chk('h386, "R7 upper mode bits ignored");

        // wrap and clear codes other than 1
        wr('h280, 0);
        wr('h381, 0);
        wr('h380, 'h00);
        wr('h388, 'h10);
        wr('h386, 'hFFFD);
        wr('h280, 2);
        idle(5);
        rd_chk('h386, "R6 wrap past 0xFFFF");
        wr('h380, 'h60);
        wr('h386, 0);
        idle(30);
        rd_chk('h386, "R6 clear code 3 keeps counting");

        // counter write priority on a running periodic channel
        wr('h280, 3);
        idle(4);
        wr('h306, 'h100);
        rd_chk('h306, "R11 counter write wins");
        wr('h306, 5);
        idle(3);
        rd_chk('h306, "R11 write of compare value");

        // channel 2 on the external input
        wr('h000, 'h04);
        wr('h008, 3);
        wr('h004, 1);
        wr('h002, 'h57);
        wr('h280, 4);
        toggle(10);
        rd_chk('h006, "R5 rising edges");
        wr('h000, 'h0C);
        toggle(9);
        rd_chk('h006, "R5 falling edges");
        wr('h000, 'h14);
        toggle(11);
        rd_chk('h006, "R5 both edges");
        wr('h000, 'h1C);
        toggle(8);
        rd_chk('h006, "R5 code 3 rising");
        wr('h000, 'h07);
        toggle(6);
        rd_chk('h006, "R4 code 7 never ticks");

        // more pin codes on channel 2
        wr('h000, 'h24);
        wr('h002, 'h61);
        toggle(12);
        wr('h002, 'h4C);
        toggle(12);
        wr('h004, 0);
        idle(3);
        wr('h002, 'h35);
        toggle(12);

        sweep("R3 final register map");
        done = 1;
        summary();
        $finish;
    end

endmodule